// File: doc/BRIEF.md
# Limit-Compare Interval Counter Timer

A free-running interval timer that advances a count field by one on every enabled tick strobe (one strobe every 500 ns, a 2 MHz count rate) and compares the next count against a programmable limit. When the next count would reach or pass the limit, the counter restarts at one tick, not zero. It also sets a sticky limit flag that drives a level interrupt. A period of N ticks therefore needs a limit of N+1.

Software sees four 32-bit registers in one window, selected by a 2-bit word address. Count and limit values sit in bits 30:9 of their registers, with bits 8:0 reading as zero. Bit 31 of both the limit and count registers shows the limit flag. Reading the limit register acknowledges the interrupt. A second limit address updates the limit without disturbing the running count or the flag.

Top module: `limit_interval_timer`

## Requirements
- R1: After reset the count register (address 1) reads 0x00000200 (count one tick, flag 0), the limit register (address 0) reads 0, the control register (address 3) reads 0, and irq is low.
- R2: With the control enable set, each cycle with tick_en high advances the count by one. The count appears in bits 30:9 of the count register, and bits 8:0 read as zero.
- R3: For a nonzero limit L, an enabled tick whose incremented count would be at least L reloads the count to one and sets the limit flag (bit 31). Limit N+1 thus gives a period of N ticks.
- R4: A limit of zero means the full field range. The counter passes through the field maximum and reloads to one on the following enabled tick.
- R5: irq is a level output equal to the limit flag. It stays high until the flag is cleared.
- R6: A read of address 0 returns the limit in bits 30:9 and the flag in bit 31, and clears the flag and irq from the next cycle on. Reads of addresses 1, 2 and 3 clear nothing. Address 2 reads the same as address 0.
- R7: A write to address 0 loads the limit from wdata bits 30:9, sets the count to one and clears the flag.
- R8: A write to address 2 loads the limit but leaves the count and the flag unchanged.
- R9: Control bit 0 enables counting. While it is 0, ticks change neither the count nor the flag.
- R10: Writes to the count register (address 1) have no effect.
- R11: If a flag-setting tick and a read of address 0 fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle count strobe, one per 500 ns |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on address 0) |
| addr | input | 2 | Register word address: 0 limit, 1 count, 2 limit without clear, 3 control |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Level interrupt, equal to the limit flag |

## Verification
Read data is combinational, so the bench samples rdata in the same cycle as the read strobe, one time step after driving it. Every write, tick and read-clear takes effect at the next rising edge. The bench drives each cycle's inputs at the falling edge and updates its reference model at the rising edge. It then compares irq and later reads against the model one step after that edge, which is the earliest cycle the new state can show. Directed cases cover the same-cycle orderings, such as a match together with an acknowledge or a limit write together with a tick. A narrow-field second instance reaches the full-range wrap within the run.

// File: rtl/limit_interval_timer.sv
module limit_interval_timer #(
  parameter int CNT_W = 22,
  parameter int SHIFT = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam logic [1:0] A_LIM = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_NCL = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, lim;
  logic             flag, en;
  logic [CNT_W:0]   nxt, lim_e;
  logic             step, match, wr_lim, wr_ncl, wr_ctl, rd_clr;
  logic             unused_bits;

  assign nxt    = {1'b0, cnt} + (CNT_W+1)'(1);
  assign lim_e  = (lim == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, lim};
  assign step   = tick_en & en;
  assign match  = step & (nxt >= lim_e);
  assign wr_lim = wr_en & (addr == A_LIM);
  assign wr_ncl = wr_en & (addr == A_NCL);
  assign wr_ctl = wr_en & (addr == A_CTL);
  assign rd_clr = rd_en & (addr == A_LIM);
  assign irq    = flag;
  assign unused_bits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= ONE;
      lim  <= '0;
      flag <= 1'b0;
      en   <= 1'b0;
    end else begin
      if (wr_lim) begin
        lim  <= wdata[SHIFT +: CNT_W];
        cnt  <= ONE;
        flag <= 1'b0;
      end else begin
        if (wr_ncl) lim <= wdata[SHIFT +: CNT_W];
        if (step) cnt <= match ? ONE : nxt[CNT_W-1:0];
        if (match) flag <= 1'b1;
        else if (rd_clr) flag <= 1'b0;
      end
      if (wr_ctl) en <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_LIM, A_NCL: begin rdata = 32'(lim) << SHIFT; rdata[31] = flag; end
      A_CNT:        begin rdata = 32'(cnt) << SHIFT; rdata[31] = flag; end
      A_CTL:        rdata[0] = en;
      default:      rdata = '0;
    endcase
  end

  a_r2_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n) cnt != '0);
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !wr_lim) |=> (cnt == ONE && flag));
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !rd_clr && !wr_lim) |=> irq);
  a_r7_limit_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (cnt == ONE && !irq));
  a_r8_noclear_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ncl && !tick_en) |=> ($stable(cnt) && $stable(flag)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_lim) |=> $stable(cnt));
endmodule

// File: tb/tb_limit_interval_timer.sv
module tb_limit_interval_timer;
  logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, rdata_w;
  logic irq, irq_w;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [21:0] m_cnt = 1, m_lim = 0;
  bit m_flag = 0, m_en = 0;

  always #5 clk = ~clk;

  limit_interval_timer dut (.clk, .rst_n, .tick_en, .wr_en, .rd_en, .addr,
    .wdata, .rdata, .irq);
  limit_interval_timer #(.CNT_W(4), .SHIFT(9)) dut_w (.clk, .rst_n, .tick_en,
    .wr_en, .rd_en, .addr, .wdata, .rdata(rdata_w), .irq(irq_w));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    logic [31:0] r;
    case (a)
      2'd0, 2'd2: begin r = 32'(m_lim) << 9; r[31] = m_flag; end
      2'd1:       begin r = 32'(m_cnt) << 9; r[31] = m_flag; end
      default:    r = {31'b0, m_en};
    endcase
    return r;
  endfunction

  task automatic model_step(bit tk, bit w, bit r, logic [1:0] a, logic [31:0] d);
    logic [22:0] nx, le;
    bit match;
    nx = {1'b0, m_cnt} + 23'd1;
    le = (m_lim == 0) ? 23'h400000 : {1'b0, m_lim};
    match = tk && m_en && (nx >= le);
    if (w && a == 0) begin
      m_lim = d[30:9]; m_cnt = 1; m_flag = 0;
    end else begin
      if (w && a == 2) m_lim = d[30:9];
      if (tk && m_en) m_cnt = match ? 22'd1 : nx[21:0];
      if (match) m_flag = 1;
      else if (r && a == 0) m_flag = 0;
    end
    if (w && a == 3) m_en = d[0];
  endtask

  task automatic cyc(string tag, bit tk, bit w, bit r, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    tick_en = tk; wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) chk(tag, rdata, exp_rd(a));
    @(posedge clk);
    model_step(tk, w, r, a, d);
    #1;
    chk({tag, "/R5 irq"}, {31'b0, irq}, {31'b0, m_flag});
  endtask

  task automatic rd(string tag, logic [1:0] a); cyc(tag, 0, 0, 1, a, 0); endtask
  task automatic wr(string tag, logic [1:0] a, logic [31:0] d); cyc(tag, 0, 1, 0, a, d); endtask
  task automatic tk(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 1, 0, 0, 2'd1, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1 count", 2'd1);
    rd("R1 limit", 2'd0);
    rd("R1 control", 2'd3);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    // R9 disabled ticks ignored
    tk("R9 disabled", 5);
    rd("R9 count held", 2'd1);
    // R4 full range on narrow instance (limit 0), both enabled
    wr("R9 enable", 2'd3, 32'd1);
    tk("R2 advance", 14);
    #1 chk("R4 narrow at max", rdata_w, 32'h0000_1E00);
    tk("R4 wrap", 1);
    #1 chk("R4 narrow reload+flag", rdata_w, 32'h8000_0200);
    chk("R4 narrow irq", {31'b0, irq_w}, 32'd1);
    rd("R2 main count", 2'd1);
    // R7 limit write, period 4 with limit 5
    wr("R7 limit", 2'd0, 32'(5) << 9);
    rd("R7 count reset", 2'd1);
    tk("R3 period", 3);
    chk("R3 no flag yet", {31'b0, irq}, 32'd0);
    tk("R3 match", 1);
    chk("R3 flag set", {31'b0, irq}, 32'd1);
    rd("R3 count reload", 2'd1);
    rd("R6 no clear on addr1", 2'd1);
    rd("R6 no clear on addr2", 2'd2);
    rd("R6 ack read", 2'd0);
    chk("R6 irq cleared", {31'b0, irq}, 32'd0);
    // R10 count write ignored
    wr("R10 count write", 2'd1, 32'h7FFF_FE00);
    rd("R10 count unchanged", 2'd1);
    // R11 match with ack in same cycle
    tk("R11 approach", 3);
    cyc("R11 match+ack", 1, 0, 1, 2'd0, 0);
    chk("R11 flag kept", {31'b0, irq}, 32'd1);
    // R8 noclear keeps count and flag
    tk("R8 pre", 2);
    wr("R8 noclear", 2'd2, 32'(40) << 9);
    rd("R8 count kept", 2'd1);
    rd("R8 limit read", 2'd2);
    // R3 limit below count matches next tick
    wr("R3 low limit", 2'd2, 32'(2) << 9);
    tk("R3 passed limit", 1);
    rd("R3 reload after pass", 2'd1);
    // R9 disable with flag, no progress
    wr("R9 disable", 2'd3, 32'd0);
    tk("R9 hold", 4);
    rd("R9 count held", 2'd1);
    wr("R9 enable", 2'd3, 32'd1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [1:0] a;
      logic [31:0] d;
      bit t;
      op = $urandom_range(0, 9);
      a = 2'($urandom_range(0, 3));
      t = ($urandom_range(0, 2) != 0);
      d = $urandom;
      if (a == 0 || a == 2) d[30:9] = 22'($urandom_range(0, 40));
      if (a == 3) d[0] = ($urandom_range(0, 4) != 0);
      if (op < 2) cyc("R6 random read", t, 0, 1, a, 0);
      else if (op == 2) cyc("R7 random write", t, 1, 0, a, d);
      else cyc("R2 random tick", t, 0, 1, 2'd1, 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule